// File: doc/BRIEF.md
# Slewed Stereo Gain Controller

This block sits between a control register file and the gain network of a stereo output stage. The register file supplies one shared target volume code and a mute request for each channel. The block then produces the gain code that is actually applied to each channel. It never jumps to a new setting. On every step tick the applied code moves one code toward its target, and otherwise it holds still.

A free-running prescaler counts system clocks and raises a one-cycle tick every `STEP_CLKS` clocks. With a 1 ms tick, a sweep across all 32 codes takes about 32 ms. Code 0 is the quietest setting and code 31 the loudest. Muting is ramped as well: a muted channel glides down to code 0, and a "muted" flag rises once code 0 is reached. After an unmute, the channel climbs from wherever it stands, which is code 0 after a completed mute.

A channel that is disabled, or any channel while software shutdown is active, is pinned at code 0 with no ramp. Both a synchronous reset and a software-reset pulse restore the power-on state: every code is 0, every muted flag is set, and the prescaler restarts from zero.

Top module: `gain_slew_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, every channel's `gain_code` field is 0 and every `muted` bit is 1.
- R2: The step tick is free running. It fires once every `STEP_CLKS` clocks, and the first tick after a reset or software reset comes on the `STEP_CLKS`-th rising edge after that reset. Applied codes change only on a tick edge, except when a hold forces code 0 (R7).
- R3: On each tick, a channel that is not held moves its code by exactly one toward its target, up or down. It stays put once the code equals the target.
- R4: A channel's target is 0 while its `mute_req` bit is 1, and `vol_code` otherwise. An unmuted channel climbs from its present code, so it starts from code 0 after a completed mute.
- R5: If the target changes during a ramp, stepping continues from the present applied code toward the new target, with no jump.
- R6: Away from reset, `muted[i]` is 1 exactly when `mute_req[i]` was 1 at the updating edge and the channel's code after that edge is 0.
- R7: If `chan_en[i]` is 0, or `sw_shutdown` is 1, channel i's code becomes 0 at the next rising edge, whether or not a tick occurs.
- R8: Each channel keeps its own code and flag. Channel i occupies bits `[i*5 +: 5]` of `gain_code`, and channel 0 is left. Muting one channel does not disturb the other.
- R9: A ramp from code 0 to code 31 takes 31 ticks, so code 31 appears 30*`STEP_CLKS` clocks after code 1.
- R10: A one-cycle `sw_reset` pulse has the same effect as `rst`, including when it lands on a tick edge: the codes go to 0, the muted flags go to 1, and the next step comes `STEP_CLKS` clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_reset | input | 1 | Software reset pulse, synchronous, active high |
| vol_code | input | GAIN_W | Target volume code shared by all channels |
| mute_req | input | NCH | Per-channel mute request |
| chan_en | input | NCH | Per-channel enable; 0 pins the channel at code 0 |
| sw_shutdown | input | 1 | Software shutdown; pins every channel at code 0 |
| gain_code | output | NCH*GAIN_W | Applied gain code per channel, channel i in bits [i*GAIN_W +: GAIN_W] |
| muted | output | NCH | Per-channel flag: mute requested and code reached 0 |

## Verification
Two events can fall on the same clock edge. A step tick can meet a software-reset pulse, and a step tick can meet a target reversal or a hold. The bench keeps its own behavioural copy of the prescaler phase. It uses that copy to fire `sw_reset` exactly on an edge where a tick is due, then expects code 0, both flags set, and a fresh full `STEP_CLKS` interval before the next step. Target reversals and holds are applied mid-ramp. The bench compares against its cycle-by-cycle model on every clock, so any partial step or extra step on such an edge shows up as a mismatch.

// File: rtl/gslew_pkg.sv
package gslew_pkg;
    parameter int unsigned GAIN_W_DEF = 5;
    parameter int unsigned NCH_DEF    = 2;

    typedef enum logic [1:0] {
        STEP_STAY = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;
endpackage

// File: rtl/gslew_tick.sv
module gslew_tick #(
    parameter int unsigned STEP_CLKS = 200000
) (
    input  logic clk,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CLKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr || (s_q.cnt == LAST)) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign tick = (s_q.cnt == LAST);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (clr)
        s_q.cnt <= LAST); // R2

    generate
        if (STEP_CLKS > 1) begin : g_spaced
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (clr)
                tick |=> !tick); // R2
        end
    endgenerate
endmodule

// File: rtl/gslew_chan.sv
module gslew_chan
    import gslew_pkg::*;
#(
    parameter int unsigned GAIN_W = GAIN_W_DEF
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              tick,
    input  logic [GAIN_W-1:0] vol,
    input  logic              mute_req,
    input  logic              hold,
    output logic [GAIN_W-1:0] code,
    output logic              muted
);
    typedef struct packed {
        logic [GAIN_W-1:0] code;
        logic              muted;
    } chan_st_t;

    chan_st_t          s_d, s_q;
    logic [GAIN_W-1:0] target;
    step_dir_e         dir;

    always_comb begin
        target = mute_req ? '0 : vol;
        if (s_q.code < target) begin
            dir = STEP_UP;
        end else if (s_q.code > target) begin
            dir = STEP_DOWN;
        end else begin
            dir = STEP_STAY;
        end

        s_d = s_q;
        if (clr) begin
            s_d.code  = '0;
            s_d.muted = 1'b1;
        end else begin
            if (hold) begin
                s_d.code = '0;
            end else if (tick) begin
                case (dir)
                    STEP_UP:   s_d.code = s_q.code + 1'b1;
                    STEP_DOWN: s_d.code = s_q.code - 1'b1;
                    default:   s_d.code = s_q.code;
                endcase
            end
            s_d.muted = mute_req && (s_d.code == '0);
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign code  = s_q.code;
    assign muted = s_q.muted;

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (clr)
        hold |=> (s_q.code == '0)); // R7

    AST_STILL_NO_TICK: assert property (@(posedge clk) disable iff (clr)
        (!tick && !hold) |=> $stable(s_q.code)); // R2

    AST_UNIT_UP: assert property (@(posedge clk) disable iff (clr)
        (tick && !hold && (s_q.code < target)) |=> (s_q.code == $past(s_q.code) + 1'b1)); // R3

    AST_UNIT_DOWN: assert property (@(posedge clk) disable iff (clr)
        (tick && !hold && (s_q.code > target)) |=> (s_q.code == $past(s_q.code) - 1'b1)); // R3

    AST_MUTED_AT_ZERO: assert property (@(posedge clk)
        s_q.muted |-> (s_q.code == '0)); // R6
endmodule

// File: rtl/gain_slew_ctrl.sv
module gain_slew_ctrl
    import gslew_pkg::*;
#(
    parameter int unsigned NCH       = NCH_DEF,
    parameter int unsigned GAIN_W    = GAIN_W_DEF,
    parameter int unsigned STEP_CLKS = 200000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sw_reset,
    input  logic [GAIN_W-1:0]     vol_code,
    input  logic [NCH-1:0]        mute_req,
    input  logic [NCH-1:0]        chan_en,
    input  logic                  sw_shutdown,
    output logic [NCH*GAIN_W-1:0] gain_code,
    output logic [NCH-1:0]        muted
);
    logic clr;
    logic tick;

    assign clr = rst | sw_reset;

    gslew_tick #(
        .STEP_CLKS(STEP_CLKS)
    ) u_tick (
        .clk (clk),
        .clr (clr),
        .tick(tick)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic hold_ch;
            assign hold_ch = !chan_en[i] || sw_shutdown;

            gslew_chan #(
                .GAIN_W(GAIN_W)
            ) u_chan (
                .clk     (clk),
                .clr     (clr),
                .tick    (tick),
                .vol     (vol_code),
                .mute_req(mute_req[i]),
                .hold    (hold_ch),
                .code    (gain_code[i*GAIN_W +: GAIN_W]),
                .muted   (muted[i])
            );
        end
    endgenerate

    AST_RESET_STATE: assert property (@(posedge clk)
        clr |=> ((gain_code == '0) && (muted == '1))); // R10
endmodule

// File: tb/gain_slew_ctrl_tb.sv
module gain_slew_ctrl_tb;
    localparam int NCH  = 2;
    localparam int GW   = 5;
    localparam int DIV  = 6;
    localparam int WDOG = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sw_reset = 1'b0;
    logic [GW-1:0]     vol_code = '0;
    logic [NCH-1:0]    mute_req = '1;
    logic [NCH-1:0]    chan_en = '1;
    logic              sw_shutdown = 1'b0;
    logic [NCH*GW-1:0] gain_code;
    logic [NCH-1:0]    muted;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;
    bit done = 0;

    int m_cnt = 0;
    int m_code[NCH];
    bit m_muted[NCH];

    always #2.5 clk = ~clk;

    gain_slew_ctrl #(.NCH(NCH), .GAIN_W(GW), .STEP_CLKS(DIV)) u_dut (
        .clk(clk), .rst(rst), .sw_reset(sw_reset), .vol_code(vol_code),
        .mute_req(mute_req), .chan_en(chan_en), .sw_shutdown(sw_shutdown),
        .gain_code(gain_code), .muted(muted)
    );

    function automatic int g(input int ch);
        return int'(gain_code[ch*GW +: GW]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst || sw_reset) begin
            m_cnt = 0;
            for (int c = 0; c < NCH; c++) begin
                m_code[c] = 0;
                m_muted[c] = 1'b1;
            end
        end else begin
            bit t;
            t = (m_cnt == DIV - 1);
            m_cnt = t ? 0 : m_cnt + 1;
            for (int c = 0; c < NCH; c++) begin
                int tgt;
                tgt = mute_req[c] ? 0 : int'(vol_code);
                if (!chan_en[c] || sw_shutdown) m_code[c] = 0;
                else if (t && m_code[c] < tgt) m_code[c]++;
                else if (t && m_code[c] > tgt) m_code[c]--;
                m_muted[c] = mute_req[c] && (m_code[c] == 0);
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (started && !done) begin
            for (int c = 0; c < NCH; c++) begin
                chk(g(c) == m_code[c], "R3 applied code vs model", g(c), m_code[c]);
                chk(muted[c] == m_muted[c], "R6 muted flag vs model", int'(muted[c]), int'(m_muted[c]));
            end
        end
        if (cycles > WDOG && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cycles, WDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int first, second, cyc;
        repeat (3) @(negedge clk);
        chk(g(0) == 0 && g(1) == 0, "R1 reset codes", g(0) + g(1), 0);
        chk(muted == 2'b11, "R1 reset muted", int'(muted), 3);
        rst = 1'b0;
        @(negedge clk);
        chk(muted == 2'b11 && gain_code == '0, "R1 after release", int'(muted), 3);

        // R9 / R2: full sweep and tick spacing
        mute_req = 2'b00;
        vol_code = 5'd31;
        first = -1; second = -1; cyc = 0;
        while (g(0) != 31 && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (g(0) == 1 && first < 0) first = cyc;
            if (g(0) == 2 && second < 0) second = cyc;
        end
        chk(second - first == DIV, "R2 tick spacing", second - first, DIV);
        chk(cyc - first == 30 * DIV, "R9 sweep length", cyc - first, 30 * DIV);
        chk(g(1) == 31, "R8 right channel swept", g(1), 31);

        // R6 / R8: mute left only
        mute_req = 2'b01;
        cyc = 0;
        while (!muted[0] && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        chk(g(0) == 0, "R6 muted left at zero", g(0), 0);
        chk(g(1) == 31 && !muted[1], "R8 right untouched", g(1), 31);

        // R4: unmute climbs from zero
        mute_req = 2'b00;
        repeat (3 * DIV) @(negedge clk);
        chk(g(0) == 3, "R4 unmute climbs from 0", g(0), 3);

        // R5: target change mid-ramp
        vol_code = 5'd20;
        repeat (10 * DIV) @(negedge clk);
        chk(g(0) == 13, "R5 left climbing", g(0), 13);
        chk(g(1) == 21, "R5 right descending", g(1), 21);
        vol_code = 5'd10;
        repeat (5 * DIV) @(negedge clk);
        chk(g(0) == 10, "R5 left reverses without jump", g(0), 10);
        chk(g(1) == 16, "R5 right continues", g(1), 16);

        // R7: shutdown and per-channel disable
        sw_shutdown = 1'b1;
        @(negedge clk);
        chk(gain_code == '0, "R7 shutdown pins zero", int'(gain_code), 0);
        sw_shutdown = 1'b0;
        chan_en = 2'b10;
        repeat (2 * DIV) @(negedge clk);
        chk(g(0) == 0, "R7 disabled left held", g(0), 0);
        chk(g(1) == 2, "R7 right ramps from 0", g(1), 2);
        chan_en = 2'b11;
        repeat (4 * DIV) @(negedge clk);

        // R10: software reset on a tick edge
        while (m_cnt != DIV - 1) @(negedge clk);
        chk(g(0) != 0, "R10 precondition nonzero", g(0), 1);
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
        chk(gain_code == '0 && muted == 2'b11, "R10 sw reset state", int'(gain_code), 0);
        repeat (DIV - 1) @(negedge clk);
        chk(g(0) == 0, "R10 no early step", g(0), 0);
        @(negedge clk);
        chk(g(0) == 1, "R10 first step after full interval", g(0), 1);

        repeat (4) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule